// File: doc/BRIEF.md
# Temperature Reading Post-Processor

This block takes raw readings from three temperature channels (remote sensor one, the on-die sensor and remote sensor two) and turns them into the values that software reads. Each raw sample is a signed number in quarter-degree steps. A per-channel signed correction, counted in half degrees, is added to the sample. The corrected value is then clamped and encoded as an 8-bit whole-degree byte plus a 2-bit quarter-degree fraction.

Two byte encodings are selectable. The default is a biased form where the byte holds the temperature plus 64, covering -64 °C to +191.75 °C. The alternative is plain twos complement, limited to -63 °C to +127.75 °C. A sensor fault from the front end replaces the reading with a fixed fault code. Each new byte is compared against a low and a high threshold for its channel. A breach latches a status bit and can pull an active-low alert output.

A single-cycle register port holds the corrections, the thresholds, the encoding select, the alert mask and the status. The analog conversion and the host bus sit outside this block.

Top module: `tmon_post`

## Requirements
- R1: After reset, all corrections read 0x00, every low threshold reads 0x01, every high threshold reads 0x7F, the encoding select reads 0, the mask reads 0, the status reads 0 and alert_n is 1.
- R2: The corrected value in quarter degrees is the raw sample plus twice the signed 8-bit correction (correction LSB = 0.5 °C, raw LSB = 0.25 °C). Sums at the extremes (raw ±1023/-1024 with correction ±127/-128) do not wrap before clamping.
- R3: In biased mode (select = 0) the value is clamped to [-256, 767] quarter degrees. It is stored as q = value + 256, with byte = q[9:2] and fraction = q[1:0].
- R4: In twos complement mode (select = 1) the value is clamped to [-252, 511] quarter degrees. It is stored with byte = value[9:2] as a twos complement number and fraction = value[1:0], so the byte spans 0xC1 to 0x7F.
- R5: A sample flagged as a sensor fault stores byte 0x00 in biased mode or 0x80 in twos complement mode, with fraction 0. It is then checked against the thresholds like any other byte.
- R6: Register 0x77 packs the fractions: remote two in bits [7:6], on-die in bits [5:4], remote one in bits [3:2]. Bits [1:0] read 0.
- R7: A stored byte above its channel's high threshold or below its low threshold sets that channel's status bit (bit 0 remote one, bit 1 on-die, bit 2 remote two). The comparison is unsigned in biased mode and signed in twos complement mode.
- R8: Status bits stay set until status (0x41) is read. The read returns the value before clearing. A breach in the same cycle as that read leaves its bit set.
- R9: alert_n is 0 exactly when some status bit is set whose mask bit is 0. The mask lives in bits [2:0] of 0x74.
- R10: In twos complement mode, a threshold write whose signed value is below -63 is stored as 0xC1. In biased mode, threshold writes are stored unchanged.
- R11: Register map:
  - corrections at 0x70, 0x71, 0x72 (remote one, on-die, remote two);
  - bytes at 0x25, 0x26, 0x27 in the same channel order;
  - thresholds at 0x4E to 0x53 as low/high pairs in that channel order;
  - encoding select in bit 1 of 0x7C, with the other bits of 0x7C reading 0.
  
  Read data appears one cycle after reg_re. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_vld | input | 1 | Raw sample valid this cycle |
| raw_ch | input | 2 | Channel of the sample: 0 remote one, 1 on-die, 2 remote two |
| raw_val | input | 11 | Signed raw sample, quarter degrees |
| raw_fault | input | 1 | Sample is a sensor fault |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the cycle after reg_re |
| alert_n | output | 1 | Active-low alert |

## Verification
The hardest case to reach from the ports is a threshold breach that lands in the same cycle as the status read that clears it. The bench drives a sample and the status read strobe on the same clock edge. It then checks two things: the returned data still shows the old status, and a second read shows the new bit.

The signed-versus-unsigned comparison is also hard to see from the ports. The bench reaches it by switching to twos complement mode and feeding a slightly negative reading. That reading would breach the default high threshold under the unsigned comparison. The bench also feeds sums at the extreme raw and correction values to confirm that clamping happens before any wrap.

// File: rtl/tmon_pkg.sv
package tmon_pkg;

    localparam int NCH    = 3;
    localparam int RAW_W  = 11;
    localparam int OFS_W  = 8;
    localparam int BYTE_W = 8;
    localparam int FRAC_W = 2;
    localparam int SUM_W  = RAW_W + 1;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        FMT_EXT  = 1'b0,
        FMT_TWOS = 1'b1
    } fmt_e;

    typedef struct packed {
        byte_t             intg;
        logic [FRAC_W-1:0] frac;
    } reading_t;

    // clamp windows in quarter degrees
    localparam int EXT_MIN_Q  = -256;
    localparam int EXT_MAX_Q  = 767;
    localparam int TWOS_MIN_Q = -252;
    localparam int TWOS_MAX_Q = 511;
    localparam int BIAS_Q     = 256;
    localparam int TWOS_FLOOR_C = -63;

    localparam byte_t FAULT_EXT  = 8'h00;
    localparam byte_t FAULT_TWOS = 8'h80;
    localparam byte_t TWOS_FLOOR = 8'hC1;
    localparam byte_t LO_RST     = 8'h01;
    localparam byte_t HI_RST     = 8'h7F;

    localparam byte_t A_READ0 = 8'h25;
    localparam byte_t A_STS   = 8'h41;
    localparam byte_t A_LIM0  = 8'h4E;
    localparam byte_t A_OFS0  = 8'h70;
    localparam byte_t A_MASK  = 8'h74;
    localparam byte_t A_FRAC  = 8'h77;
    localparam byte_t A_CFG   = 8'h7C;
    localparam int    CFG_FMT_BIT = 1;

    function automatic byte_t floor_limit(byte_t v, fmt_e f);
        if (f == FMT_TWOS && $signed(v) < TWOS_FLOOR_C)
            return TWOS_FLOOR;
        return v;
    endfunction

endpackage

// File: rtl/tmon_fmt.sv
module tmon_fmt
    import tmon_pkg::*;
#(
    parameter int RW = RAW_W,
    parameter int OW = OFS_W,
    parameter int SW = RW + 1
) (
    input  logic signed [RW-1:0] raw,
    input  logic [OW-1:0]        ofs,
    input  logic                 fault,
    input  fmt_e                 fmt,
    output reading_t             enc
);

    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] lo_q;
    logic signed [SW-1:0] hi_q;
    logic signed [SW-1:0] lim_q;
    logic [SW-1:0]        biased;

    always_comb begin
        sum = $signed({{(SW-RW){raw[RW-1]}}, raw})
            + $signed({{(SW-OW-1){ofs[OW-1]}}, ofs, 1'b0});
        lo_q = (fmt == FMT_TWOS) ? SW'(TWOS_MIN_Q) : SW'(EXT_MIN_Q);
        hi_q = (fmt == FMT_TWOS) ? SW'(TWOS_MAX_Q) : SW'(EXT_MAX_Q);
        if (sum < lo_q)
            lim_q = lo_q;
        else if (sum > hi_q)
            lim_q = hi_q;
        else
            lim_q = sum;
        biased = lim_q + SW'(BIAS_Q);

        if (fault) begin
            enc.intg = (fmt == FMT_TWOS) ? FAULT_TWOS : FAULT_EXT;
            enc.frac = '0;
        end else if (fmt == FMT_TWOS) begin
            enc.intg = lim_q[FRAC_W +: BYTE_W];
            enc.frac = lim_q[FRAC_W-1:0];
        end else begin
            enc.intg = biased[FRAC_W +: BYTE_W];
            enc.frac = biased[FRAC_W-1:0];
        end
    end

endmodule

// File: rtl/tmon_cmp.sv
module tmon_cmp
    import tmon_pkg::*;
(
    input  byte_t val,
    input  byte_t lo,
    input  byte_t hi,
    input  fmt_e  fmt,
    output logic  breach
);

    always_comb begin
        if (fmt == FMT_TWOS)
            breach = ($signed(val) > $signed(hi)) || ($signed(val) < $signed(lo));
        else
            breach = (val > hi) || (val < lo);
    end

endmodule

// File: rtl/tmon_post.sv
module tmon_post
    import tmon_pkg::*;
#(
    parameter int N        = NCH,
    parameter int RAW_BITS = RAW_W,
    parameter int SEL_W    = $clog2(N)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       raw_vld,
    input  logic [SEL_W-1:0]           raw_ch,
    input  logic signed [RAW_BITS-1:0] raw_val,
    input  logic                       raw_fault,
    input  logic                       reg_we,
    input  logic                       reg_re,
    input  logic [7:0]                 reg_addr,
    input  logic [7:0]                 reg_wdata,
    output logic [7:0]                 reg_rdata,
    output logic                       alert_n
);

    byte_t    [N-1:0] ofs_q;
    byte_t    [N-1:0] lo_q;
    byte_t    [N-1:0] hi_q;
    reading_t [N-1:0] rd_q;
    fmt_e             mode;
    logic     [N-1:0] sts;
    logic     [N-1:0] mask;
    logic     [N-1:0] breach;
    logic     [N-1:0] hit;
    reading_t         enc;
    byte_t            ofs_sel;
    byte_t            rd_mux;
    logic             ch_ok;
    logic             sts_rd;

    assign ch_ok   = (32'(raw_ch) < N);
    assign ofs_sel = ch_ok ? ofs_q[raw_ch] : '0;
    assign sts_rd  = reg_re && (reg_addr == A_STS);

    tmon_fmt #(.RW(RAW_BITS), .OW(OFS_W)) u_fmt (
        .raw   (raw_val),
        .ofs   (ofs_sel),
        .fault (raw_fault),
        .fmt   (mode),
        .enc   (enc)
    );

    for (genvar g = 0; g < N; g++) begin : g_chan
        tmon_cmp u_cmp (
            .val    (enc.intg),
            .lo     (lo_q[g]),
            .hi     (hi_q[g]),
            .fmt    (mode),
            .breach (breach[g])
        );
        assign hit[g] = raw_vld && ch_ok && (raw_ch == SEL_W'(g)) && breach[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q <= '0;
            rd_q  <= '0;
            mode  <= FMT_EXT;
            mask  <= '0;
            sts   <= '0;
            for (int i = 0; i < N; i++) begin
                lo_q[i] <= LO_RST;
                hi_q[i] <= HI_RST;
            end
        end else begin
            if (reg_we) begin
                if (reg_addr == A_CFG)
                    mode <= fmt_e'(reg_wdata[CFG_FMT_BIT]);
                if (reg_addr == A_MASK)
                    mask <= reg_wdata[N-1:0];
                for (int i = 0; i < N; i++) begin
                    if (reg_addr == A_OFS0 + 8'(i))
                        ofs_q[i] <= reg_wdata;
                    if (reg_addr == A_LIM0 + 8'(2*i))
                        lo_q[i] <= floor_limit(reg_wdata, mode);
                    if (reg_addr == A_LIM0 + 8'(2*i+1))
                        hi_q[i] <= floor_limit(reg_wdata, mode);
                end
            end
            if (raw_vld && ch_ok)
                rd_q[raw_ch] <= enc;
            sts <= (sts_rd ? '0 : sts) | hit;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (reg_addr == A_CFG)
            rd_mux[CFG_FMT_BIT] = mode;
        if (reg_addr == A_MASK)
            rd_mux[N-1:0] = mask;
        if (reg_addr == A_STS)
            rd_mux[N-1:0] = sts;
        for (int i = 0; i < N; i++) begin
            if (reg_addr == A_FRAC)
                rd_mux[2*i+2 +: 2] = rd_q[i].frac;
            if (reg_addr == A_READ0 + 8'(i))
                rd_mux = rd_q[i].intg;
            if (reg_addr == A_OFS0 + 8'(i))
                rd_mux = ofs_q[i];
            if (reg_addr == A_LIM0 + 8'(2*i))
                rd_mux = lo_q[i];
            if (reg_addr == A_LIM0 + 8'(2*i+1))
                rd_mux = hi_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            reg_rdata <= '0;
        else if (reg_re)
            reg_rdata <= rd_mux;
    end

    assign alert_n = ~|(sts & ~mask);

endmodule

// File: rtl/tmon_post_chk.sv
module tmon_post_chk
    import tmon_pkg::*;
#(
    parameter int N     = NCH,
    parameter int SEL_W = $clog2(N)
) (
    input logic             clk,
    input logic             rst,
    input logic             raw_vld,
    input logic [SEL_W-1:0] raw_ch,
    input logic             raw_fault,
    input logic             reg_we,
    input logic             reg_re,
    input logic [7:0]       reg_addr,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       reg_rdata,
    input logic             alert_n,
    input fmt_e             mode,
    input logic [N-1:0]     sts,
    input reading_t [N-1:0] rd_q,
    input byte_t [N-1:0]    lo_lim,
    input byte_t [N-1:0]    hi_lim
);

    logic [SEL_W-1:0] last_ch;
    fmt_e             last_mode;
    byte_t            last_addr;
    reading_t         sel_rd;
    byte_t            sel_lim;
    byte_t            lim_off;
    logic             ch_ok;
    logic             is_lim;

    always_ff @(posedge clk) begin
        last_ch   <= raw_ch;
        last_mode <= mode;
        last_addr <= reg_addr;
    end

    assign ch_ok   = (32'(raw_ch) < N);
    assign sel_rd  = (32'(last_ch) < N) ? rd_q[last_ch] : '0;
    assign lim_off = last_addr - A_LIM0;
    assign is_lim  = (32'(byte_t'(reg_addr - A_LIM0)) < 2*N);

    always_comb begin
        sel_lim = '0;
        for (int i = 0; i < N; i++) begin
            if (lim_off == 8'(2*i))   sel_lim = lo_lim[i];
            if (lim_off == 8'(2*i+1)) sel_lim = hi_lim[i];
        end
    end

    AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (sts == '0 && alert_n)); // R1
    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (rst) (raw_vld && raw_fault && ch_ok) |=> (sel_rd.intg == ((last_mode == FMT_TWOS) ? FAULT_TWOS : FAULT_EXT) && sel_rd.frac == '0)); // R5
    AST_TWOS_RANGE: assert property (@(posedge clk) disable iff (rst) (raw_vld && !raw_fault && ch_ok && mode == FMT_TWOS) |=> ($signed(sel_rd.intg) >= TWOS_FLOOR_C)); // R4
    AST_FRAC_TAIL: assert property (@(posedge clk) disable iff (rst) (reg_re && reg_addr == A_FRAC) |=> (reg_rdata[1:0] == 2'b00)); // R6
    AST_STICKY: assert property (@(posedge clk) disable iff (rst) !(reg_re && reg_addr == A_STS) |=> ((sts & $past(sts)) == $past(sts))); // R8
    AST_ALERT_SRC: assert property (@(posedge clk) disable iff (rst) !alert_n |-> (sts != '0)); // R9
    AST_LIM_FLOOR: assert property (@(posedge clk) disable iff (rst) (reg_we && mode == FMT_TWOS && is_lim && $signed(reg_wdata) < TWOS_FLOOR_C) |=> (sel_lim == TWOS_FLOOR)); // R10

endmodule

bind tmon_post tmon_post_chk #(.N(N), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .raw_vld   (raw_vld),
    .raw_ch    (raw_ch),
    .raw_fault (raw_fault),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .alert_n   (alert_n),
    .mode      (mode),
    .sts       (sts),
    .rd_q      (rd_q),
    .lo_lim    (lo_q),
    .hi_lim    (hi_q)
);

// File: tb/tmon_post_bench.sv
`timescale 1ns/100ps
module tmon_post_bench;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              raw_vld = 1'b0;
    logic [1:0]        raw_ch = '0;
    logic signed [10:0] raw_val = '0;
    logic              raw_fault = 1'b0;
    logic              reg_we = 1'b0;
    logic              reg_re = 1'b0;
    logic [7:0]        reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              alert_n;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    tmon_post u_tmon_post (
        .clk       (clk),
        .rst       (rst),
        .raw_vld   (raw_vld),
        .raw_ch    (raw_ch),
        .raw_val   (raw_val),
        .raw_fault (raw_fault),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .alert_n   (alert_n)
    );

    // {mode, ch, fault, raw[11:0], ofs, byte, frac} as 44-bit hex
    localparam int NV = 16;
    localparam logic [43:0] VEC [NV] = '{
        44'h0_0_0_064_00_59_0,
        44'h0_1_0_065_04_5B_1,
        44'h0_2_0_ED4_00_00_0,
        44'h0_0_0_3E8_00_FF_3,
        44'h0_1_0_2F8_7F_FF_3,
        44'h0_2_0_FFD_FE_3E_1,
        44'h1_0_0_064_00_19_0,
        44'h1_1_0_FFF_00_FF_3,
        44'h1_2_0_ED4_00_C1_0,
        44'h1_0_0_258_00_7F_3,
        44'h1_1_0_F06_80_C1_0,
        44'h0_0_1_064_00_00_0,
        44'h1_2_1_064_00_80_0,
        44'h1_2_0_3FF_7F_7F_3,
        44'h0_0_0_C00_80_00_0,
        44'h0_1_0_FFF_00_3F_3
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    task automatic smp(input logic [1:0] ch, input logic signed [10:0] v, input logic f);
        @(negedge clk);
        raw_vld = 1'b1; raw_ch = ch; raw_val = v; raw_fault = f;
        @(negedge clk);
        raw_vld = 1'b0; raw_fault = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 alert_n", {7'd0, alert_n}, 8'h01);
        for (int c = 0; c < 3; c++) begin
            rd(8'h70 + 8'(c), d); check("R1 offset", d, 8'h00);
            rd(8'h4E + 8'(2*c), d); check("R1 low limit", d, 8'h01);
            rd(8'h4F + 8'(2*c), d); check("R1 high limit", d, 8'h7F);
        end
        rd(8'h7C, d); check("R1 config", d, 8'h00);
        rd(8'h74, d); check("R1 mask", d, 8'h00);
        rd(8'h41, d); check("R1 status", d, 8'h00);
        rd(8'h10, d); check("R11 unmapped", d, 8'h00);

        // vector table: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            logic [43:0] v;
            logic [1:0]  ch;
            logic [7:0]  ofs;
            string       tag;
            v   = VEC[i];
            ch  = v[37:36];
            ofs = v[19:12];
            if (v[32])          tag = "R5";
            else if (ofs != 0)  tag = "R2";
            else if (v[40])     tag = "R4";
            else                tag = "R3";
            wr(8'h7C, {6'd0, v[40], 1'b0});
            wr(8'h70 + 8'(ch), ofs);
            smp(ch, v[30:20], v[32]);
            rd(8'h25 + 8'(ch), d);
            check($sformatf("%s byte vec%0d", tag, i), d, v[11:4]);
            rd(8'h77, d);
            check($sformatf("%s frac vec%0d", tag, i), {6'd0, d[2*ch+2 +: 2]}, {6'd0, v[1:0]});
            check("R6 frac low bits", {6'd0, d[1:0]}, 8'h00);
        end

        // clean up
        wr(8'h7C, 8'h00);
        for (int c = 0; c < 3; c++) wr(8'h70 + 8'(c), 8'h00);
        rd(8'h41, d);
        rd(8'h41, d); check("R8 cleared", d, 8'h00);
        check("R9 alert idle", {7'd0, alert_n}, 8'h01);

        // R7 high threshold, biased mode
        wr(8'h51, 8'h60);
        smp(2'd1, 11'sd128, 1'b0);
        check("R7 at limit no alert", {7'd0, alert_n}, 8'h01);
        smp(2'd1, 11'sd132, 1'b0);
        check("R9 alert low", {7'd0, alert_n}, 8'h00);
        smp(2'd1, 11'sd128, 1'b0);
        rd(8'h41, d); check("R8 sticky R7 high", d, 8'h02);
        rd(8'h41, d); check("R8 clear on read", d, 8'h00);
        check("R9 alert released", {7'd0, alert_n}, 8'h01);

        // R7 low threshold, biased mode
        smp(2'd0, -11'sd256, 1'b0);
        rd(8'h41, d); check("R7 low breach", d, 8'h01);

        // R9 mask
        wr(8'h74, 8'h04);
        smp(2'd2, 11'sd1000, 1'b0);
        check("R9 masked alert", {7'd0, alert_n}, 8'h01);
        rd(8'h74, d); check("R11 mask readback", d, 8'h04);
        rd(8'h41, d); check("R9 masked status", d, 8'h04);
        wr(8'h74, 8'h00);

        // R8 breach in the same cycle as the clearing read
        @(negedge clk);
        raw_vld = 1'b1; raw_ch = 2'd1; raw_val = 11'sd132;
        reg_re = 1'b1; reg_addr = 8'h41;
        @(negedge clk);
        raw_vld = 1'b0; reg_re = 1'b0;
        check("R8 old value on read", reg_rdata, 8'h00);
        rd(8'h41, d); check("R8 set wins over clear", d, 8'h02);

        // R10 floor and R7 signed compare in twos complement mode
        wr(8'h7C, 8'hFF);
        rd(8'h7C, d); check("R11 config bit", d, 8'h02);
        wr(8'h52, 8'h80);
        rd(8'h52, d); check("R10 floored", d, 8'hC1);
        wr(8'h52, 8'hC5);
        rd(8'h52, d); check("R10 kept", d, 8'hC5);
        smp(2'd2, -11'sd4, 1'b0);
        rd(8'h41, d); check("R7 signed compare", d, 8'h00);
        smp(2'd2, 11'sd0, 1'b1);
        rd(8'h41, d); check("R5 fault below low", d, 8'h04);

        // R10 biased mode keeps raw write
        wr(8'h7C, 8'h00);
        wr(8'h50, 8'h80);
        rd(8'h50, d); check("R10 biased unchanged", d, 8'h80);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule